// File: doc/BRIEF.md
# Interconnect Open/Short Test Vector Generator

This block produces the parallel stimulus for a board interconnect test over a set of nets, then judges the responses captured from those nets. Each net gets a binary code that is unique to it and is neither all zeros nor all ones. The block then sends one parallel vector per code bit. In vector k, each net is driven with bit k of its own code. With this set of vectors, every net takes both logic levels, which exposes opens. Every pair of nets is also driven to opposite levels at least once, which exposes shorts between two nets. A short that involves more nets is then exposed as well.

A controller pulses `start`. The block offers each vector with a valid/ready handshake. It then waits for the matching response word. It compares that word bit by bit with the vector that was sent, and only then moves to the next vector. A mismatch on any vector sets a sticky fail flag. A one-cycle done pulse marks the end of the run. The block does not work out which nets are shorted.

Top module: `netcode_vecgen`

## Requirements
- R1: A run emits exactly W = ceil(log2(NUM_NETS+2)) vectors, which is the fewest that can give every net a distinct code that excludes all-zero and all-one.
- R2: Net i has code i+1, which is W bits wide. Vector k, for k = 0 up to W-1 in that order, carries bit k of net i's code on vec_data bit i.
- R3: Across one run, every net sees at least one 0 and at least one 1.
- R4: Across one run, any two distinct nets receive opposite values in at least one vector.
- R5: While vec_valid is high and vec_ready is low, vec_valid stays high and vec_data does not change.
- R6: A vector is consumed only on a cycle where vec_valid and vec_ready are both high. The next vector is offered only after the response to the current vector has been accepted with resp_valid.
- R7: A response word that differs from its vector in any bit sets fail. fail then stays high until the next accepted start, which clears it.
- R8: done is high for exactly one cycle, in the cycle after the last response is accepted, and fail already includes the result of that last comparison.
- R9: start has no effect while a run is in progress. resp_valid has no effect unless the block is waiting for a response.
- R10: After reset, vec_valid, done and fail are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken when idle) |
| vec_data | output | NUM_NETS | Parallel test vector, one bit per net |
| vec_valid | output | 1 | vec_data is offered |
| vec_ready | input | 1 | Consumer takes vec_data |
| resp_data | input | NUM_NETS | Captured response word for the current vector |
| resp_valid | input | 1 | resp_data is present |
| fail | output | 1 | Sticky miscompare flag |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with NUM_NETS = 6. This gives W = 3 and codes 1 through 6. The largest code then sits just below the excluded all-ones value 7, so the exclusion boundary and the shortest code length are both exercised. Runs are made with ready held off, with stray start and resp_valid pulses during the vector offer, and with a single flipped response bit. These runs cover stalls, ignored inputs, the sticky flag and its clearing on the next run.

// File: rtl/netcode_pkg.sv
package netcode_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEND = 2'd1,
        PH_WAIT = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    // Bits needed so that codes 1..n all fit without reaching all-ones.
    function automatic int code_width(input int n);
        return $clog2(n + 2);
    endfunction

    function automatic int index_width(input int w);
        return (w < 2) ? 1 : $clog2(w);
    endfunction

endpackage

// File: rtl/netcode_pattern.sv
module netcode_pattern
    import netcode_pkg::*;
#(
    parameter int NUM_NETS = 8,
    parameter int CODE_W   = code_width(NUM_NETS),
    parameter int IDX_W    = index_width(CODE_W)
) (
    input  logic [IDX_W-1:0]    bit_sel,
    output logic [NUM_NETS-1:0] pattern
);

    for (genvar n = 0; n < NUM_NETS; n++) begin : g_net
        localparam logic [CODE_W-1:0] NET_CODE = CODE_W'(n + 1);
        assign pattern[n] = NET_CODE[bit_sel];
    end

endmodule

// File: rtl/netcode_seq.sv
module netcode_seq
    import netcode_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int IDX_W  = index_width(CODE_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             vec_ready,
    input  logic             resp_valid,
    output logic             vec_valid,
    output logic [IDX_W-1:0] bit_sel,
    output logic             cmp_en,
    output logic             clr,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_W - 1);

    phase_e           phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        clr     = 1'b0;
        cmp_en  = 1'b0;
        unique case (phase_q)
            PH_IDLE: if (start) begin
                phase_d = PH_SEND;
                idx_d   = '0;
                clr     = 1'b1;
            end
            PH_SEND: if (vec_ready) phase_d = PH_WAIT;
            PH_WAIT: if (resp_valid) begin
                cmp_en = 1'b1;
                if (idx_q == LAST_IDX) phase_d = PH_DONE;
                else begin
                    idx_d   = idx_q + 1'b1;
                    phase_d = PH_SEND;
                end
            end
            PH_DONE: phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
        end
    end

    assign vec_valid = (phase_q == PH_SEND);
    assign done      = (phase_q == PH_DONE);
    assign bit_sel   = idx_q;

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !vec_ready) |=> (vec_valid && $stable(bit_sel)));

    assert_wait_resp_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WAIT && !resp_valid) |=> (phase_q == PH_WAIT && !vec_valid));

    assert_index_range_R1: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (bit_sel <= LAST_IDX));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !vec_ready) |=> !done);

endmodule

// File: rtl/netcode_judge.sv
module netcode_judge #(
    parameter int NUM_NETS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                cmp_en,
    input  logic [NUM_NETS-1:0] observed,
    input  logic [NUM_NETS-1:0] expected,
    output logic                fail
);

    logic mismatch;
    assign mismatch = |(observed ^ expected);

    always_ff @(posedge clk) begin
        if (rst)                      fail <= 1'b0;
        else if (clr)                 fail <= 1'b0;
        else if (cmp_en && mismatch)  fail <= 1'b1;
    end

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (fail && !clr) |=> fail);

    assert_set_R7: assert property (@(posedge clk) disable iff (rst)
        (cmp_en && !clr && (observed != expected)) |=> fail);

endmodule

// File: rtl/netcode_vecgen.sv
module netcode_vecgen
    import netcode_pkg::*;
#(
    parameter int NUM_NETS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    output logic [NUM_NETS-1:0] vec_data,
    output logic                vec_valid,
    input  logic                vec_ready,
    input  logic [NUM_NETS-1:0] resp_data,
    input  logic                resp_valid,
    output logic                fail,
    output logic                done
);

    localparam int CODE_W = code_width(NUM_NETS);
    localparam int IDX_W  = index_width(CODE_W);

    logic [IDX_W-1:0]    bit_sel;
    logic                cmp_en;
    logic                clr;
    logic [NUM_NETS-1:0] pattern;

    netcode_seq #(.CODE_W(CODE_W), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .vec_ready  (vec_ready),
        .resp_valid (resp_valid),
        .vec_valid  (vec_valid),
        .bit_sel    (bit_sel),
        .cmp_en     (cmp_en),
        .clr        (clr),
        .done       (done)
    );

    netcode_pattern #(.NUM_NETS(NUM_NETS), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_pattern (
        .bit_sel (bit_sel),
        .pattern (pattern)
    );

    netcode_judge #(.NUM_NETS(NUM_NETS)) u_judge (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .cmp_en   (cmp_en),
        .observed (resp_data),
        .expected (pattern),
        .fail     (fail)
    );

    assign vec_data = pattern;

    assert_data_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !vec_ready) |=> $stable(vec_data));

    assert_reset_R10: assert property (@(posedge clk)
        $past(rst) |-> (!vec_valid && !done && !fail));

endmodule

// File: tb/netcode_vecgen_bench.sv
module netcode_vecgen_bench;

    localparam int N = 6;
    localparam int W = $clog2(N + 2);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [N-1:0] vec_data;
    logic         vec_valid;
    logic         vec_ready = 1'b0;
    logic [N-1:0] resp_data = '0;
    logic         resp_valid = 1'b0;
    logic         fail;
    logic         done;

    always #10 clk = ~clk;

    netcode_vecgen #(.NUM_NETS(N)) u_netcode_vecgen (
        .clk(clk), .rst(rst), .start(start),
        .vec_data(vec_data), .vec_valid(vec_valid), .vec_ready(vec_ready),
        .resp_data(resp_data), .resp_valid(resp_valid),
        .fail(fail), .done(done)
    );

    int applied = 0;
    int miscompares = 0;
    int checks = 0;
    int cycles = 0;
    int run_applied = 0;
    bit live = 1'b0;

    // behavioural reference model
    int ph = 0;   // 0 idle, 1 offering, 2 awaiting response, 3 finished
    int idx = 0;
    bit mfail = 1'b0;

    function automatic logic [N-1:0] expv(input int k);
        logic [N-1:0] r;
        for (int n = 0; n < N; n++) r[n] = (((n + 1) >> k) & 1) != 0;
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            ph = 0; idx = 0; mfail = 1'b0;
        end else begin
            case (ph)
                0: if (start) begin ph = 1; idx = 0; mfail = 1'b0; end
                1: if (vec_ready) begin ph = 2; applied++; run_applied++; end
                2: if (resp_valid) begin
                    if (resp_data != expv(idx)) mfail = 1'b1;
                    if (idx == W - 1) ph = 3;
                    else begin idx++; ph = 1; end
                end
                default: ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (live && !rst) begin
            check("R6 vec_valid", 32'(vec_valid), 32'(ph == 1));
            if (ph == 1) check("R2 vec_data", 32'(vec_data), 32'(expv(idx)));
            check("R8 done", 32'(done), 32'(ph == 3));
            check("R7 fail", 32'(fail), 32'(mfail));
        end
    end

    logic [N-1:0] cap [W];

    task automatic run(input int flip_k, input logic [N-1:0] mask, input int lag, input bit poke);
        run_applied = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < W; k++) begin
            while (ph != 1) @(negedge clk);
            for (int l = 0; l < lag; l++) begin
                if (poke) begin start = 1'b1; resp_valid = 1'b1; resp_data = '1; end
                @(negedge clk);
                check("R5 held vector", 32'(vec_data), 32'(expv(k)));
            end
            start = 1'b0; resp_valid = 1'b0;
            vec_ready = 1'b1;
            cap[k] = vec_data;
            @(negedge clk);
            vec_ready = 1'b0;
            if (lag > 0) @(negedge clk);   // response arrives late
            resp_valid = 1'b1;
            resp_data = expv(k) ^ ((k == flip_k) ? mask : '0);
            @(negedge clk);
            resp_valid = 1'b0;
        end
        check("R8 done after last response", 32'(done), 32'd1);
        @(negedge clk);
        check("R1 vectors per run", 32'(run_applied), 32'(W));
        for (int a = 0; a < N; a++) begin
            int ca = 0;
            for (int k = 0; k < W; k++) ca |= int'(cap[k][a]) << k;
            check("R3 net sees a 0", 32'(ca != (1 << W) - 1), 32'd1);
            check("R3 net sees a 1", 32'(ca != 0), 32'd1);
            for (int b = a + 1; b < N; b++) begin
                int cb = 0;
                for (int k = 0; k < W; k++) cb |= int'(cap[k][b]) << k;
                check("R4 pair differs", 32'(ca != cb), 32'd1);
            end
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R10 valid after reset", 32'(vec_valid), 32'd0);
        check("R10 done after reset", 32'(done), 32'd0);
        check("R10 fail after reset", 32'(fail), 32'd0);
        live = 1'b1;
        resp_valid = 1'b1;            // stray response while idle: R9
        @(negedge clk);
        resp_valid = 1'b0;
        check("R9 idle resp ignored", 32'(fail), 32'd0);
        run(-1, '0, 0, 1'b0);
        check("R7 clean run passes", 32'(fail), 32'd0);
        run(1, 6'b000100, 3, 1'b1);
        check("R7 flipped bit fails", 32'(fail), 32'd1);
        repeat (3) @(negedge clk);
        check("R7 fail is sticky", 32'(fail), 32'd1);
        run(-1, '0, 2, 1'b0);
        check("R7 start clears fail", 32'(fail), 32'd0);
        run(W - 1, 6'b100000, 0, 1'b0);
        check("R7 last vector miscompare", 32'(fail), 32'd1);
        live = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        wait (cycles > 5000);
        miscompares++;
        $display("FAIL watchdog actual=%0d expected<5000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule